// File: doc/BRIEF.md
# Turn-On Delay Register and Ramp-Start Timer

This block holds a 16-bit power-up delay command word and times the gap between an enable event and the start of an output ramp. A register-write port presents a full 16-bit word. Only the three low bits, the delay code, can be changed. The upper thirteen bits are fixed: a five-bit two's-complement exponent of all ones, which gives a 0.5 ms step, and eight reserved zero bits. A word that tries to change any fixed bit is refused. A refused word gets a not-acknowledge, leaves the stored value as it was, and raises two sticky error flags.

On each rising edge of the start request, the timer latches the delay chosen by the stored code. It then counts microsecond ticks, which a parameterised prescaler derives from the system clock. When the count is complete it issues a one-cycle ramp-start pulse. The delay set is coarse and non-linear:

| Code | Delay |
|---|---|
| 0 | 50 µs |
| 1 | 500 µs |
| 2 | 1000 µs |
| 3 to 7 | 2000 µs |

If the start request is withdrawn during the count, the timer goes back to idle and no pulse is issued. The code can be rewritten at any time. A new code governs the next start event and does not affect a count already in progress.

Top module: `startup_delay_unit`

## Requirements
- R1: After reset the read word is 16'hF800 (code 0), both error flags are low, and no acknowledge or ramp pulse is active.
- R2: A write whose bits 15:3 equal 13'h1F00 is acknowledged (wr_ack high for one cycle, the cycle after wr_en). Its bits 2:0 then read back exactly on rd_data[2:0] from that cycle on.
- R3: A write whose bits 15:3 differ from 13'h1F00 is refused with wr_nack for one cycle instead of wr_ack, and rd_data keeps its previous value.
- R4: A refused write sets err_summary and err_data in the cycle after wr_en. Both flags stay set through later accepted writes until err_clr is asserted, which clears them on the next cycle.
- R5: With code 0, ramp_go follows the start edge after 50 prescaler ticks.
- R6: Code 1 gives 500 ticks and code 2 gives 1000 ticks.
- R7: Codes 3, 4, 5, 6 and 7 all give 2000 ticks.
- R8: ramp_go is a single-cycle pulse. Holding start_req high after the pulse does not start another delay; only a new rising edge does.
- R9: Dropping start_req before the delay ends returns the timer to idle, and no ramp_go is issued for that start.
- R10: A code written during an active delay does not change that delay; it applies from the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 16 | Word to be written |
| wr_ack | output | 1 | Write accepted, one cycle after wr_en |
| wr_nack | output | 1 | Write refused, one cycle after wr_en |
| rd_data | output | 16 | Current register word |
| err_clr | input | 1 | Clears both sticky error flags |
| err_summary | output | 1 | Sticky summary communication-error flag |
| err_data | output | 1 | Sticky invalid-data flag |
| start_req | input | 1 | Start condition; a rising edge starts a delay |
| ramp_go | output | 1 | One-cycle ramp-start pulse |

## Verification
The in-RTL assertions check the following on every cycle:
- every write strobe gets exactly one of acknowledge or not-acknowledge;
- a refused write leaves the code unchanged;
- both error flags move together and stay set until cleared;
- the prescaler stays in range;
- ramp_go is never two cycles wide and never follows a cycle with start_req low.

Only the bench scenarios can show that each code produces the right tick count, within one tick of prescaler phase. The same applies to the code latched at the start edge governing the delay in progress, and to a held start request producing only one pulse.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned CODE_W  = 3;
   localparam int unsigned FIXED_W = WORD_W - CODE_W;
   // exponent 5'b11111 followed by eight reserved zeros
   localparam logic [FIXED_W-1:0] FIXED_BITS = 13'h1F00;

   typedef enum logic [0:0] {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_t;
endpackage

// File: rtl/sdu_tick_gen.sv
module sdu_tick_gen #(
   parameter int unsigned CLK_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (CLK_PER_US < 1) begin : g_bad_div
      $error("sdu_tick_gen: CLK_PER_US must be at least 1");
   end

   if (CLK_PER_US == 1) begin : g_direct
      assign tick = 1'b1;
   end else begin : g_div
      localparam int unsigned DW = $clog2(CLK_PER_US);
      localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             div_q <= '0;
         else if (div_q == LAST) div_q <= '0;
         else                    div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
         div_q <= LAST);
   end
endmodule

// File: rtl/sdu_cfg_reg.sv
module sdu_cfg_reg
   import sdu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              err_clr,
   output logic              wr_ack,
   output logic              wr_nack,
   output logic              err_summary,
   output logic              err_data,
   output logic [CODE_W-1:0] code
);
   logic              fixed_ok;
   logic [CODE_W-1:0] code_q;
   logic              ack_q, nack_q, sum_q, dat_q;

   assign fixed_ok = (wr_data[WORD_W-1:CODE_W] == FIXED_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         ack_q  <= 1'b0;
         nack_q <= 1'b0;
         sum_q  <= 1'b0;
         dat_q  <= 1'b0;
      end else begin
         ack_q  <= wr_en &&  fixed_ok;
         nack_q <= wr_en && !fixed_ok;
         if (wr_en && fixed_ok) code_q <= wr_data[CODE_W-1:0];
         // a new error in the same cycle as a clear wins
         if (wr_en && !fixed_ok) begin
            sum_q <= 1'b1;
            dat_q <= 1'b1;
         end else if (err_clr) begin
            sum_q <= 1'b0;
            dat_q <= 1'b0;
         end
      end
   end

   assign code        = code_q;
   assign wr_ack      = ack_q;
   assign wr_nack     = nack_q;
   assign err_summary = sum_q;
   assign err_data    = dat_q;

   assert_one_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wr_ack ^ wr_nack));
   assert_refused_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !fixed_ok) |=> (code_q == $past(code_q)));
   assert_flags_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_summary == err_data);
   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_summary && !err_clr) |=> err_summary);
endmodule

// File: rtl/sdu_delay_timer.sv
module sdu_delay_timer
   import sdu_pkg::*;
#(
   parameter int unsigned TICKS_C0   = 50,
   parameter int unsigned TICKS_C1   = 500,
   parameter int unsigned TICKS_C2   = 1000,
   parameter int unsigned TICKS_CMAX = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_req,
   input  logic [CODE_W-1:0] code,
   output logic              ramp_go
);
   localparam int unsigned CW = $clog2(TICKS_CMAX + 1);

   if (TICKS_C0 < 1 || TICKS_C0 > TICKS_C1 || TICKS_C1 > TICKS_C2 ||
       TICKS_C2 > TICKS_CMAX) begin : g_bad_ticks
      $error("sdu_delay_timer: tick counts must be nonzero and ascending");
   end

   tmr_state_t    st_q;
   logic [CW-1:0] cnt_q, lim_q, lim_sel;
   logic          prev_q, go_q;

   always_comb begin
      case (code)
         3'd0:    lim_sel = CW'(TICKS_C0);
         3'd1:    lim_sel = CW'(TICKS_C1);
         3'd2:    lim_sel = CW'(TICKS_C2);
         default: lim_sel = CW'(TICKS_CMAX);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TMR_IDLE;
         cnt_q  <= '0;
         lim_q  <= '0;
         prev_q <= 1'b0;
         go_q   <= 1'b0;
      end else begin
         prev_q <= start_req;
         go_q   <= 1'b0;
         case (st_q)
            TMR_IDLE: begin
               if (start_req && !prev_q) begin
                  st_q  <= TMR_RUN;
                  cnt_q <= '0;
                  lim_q <= lim_sel;
               end
            end
            TMR_RUN: begin
               if (!start_req) begin
                  st_q <= TMR_IDLE;
               end else if (tick) begin
                  if (cnt_q == lim_q - 1'b1) begin
                     go_q <= 1'b1;
                     st_q <= TMR_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= TMR_IDLE;
         endcase
      end
   end

   assign ramp_go = go_q;

   assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_go |=> !ramp_go);
   assert_no_go_after_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start_req |=> !ramp_go);
   assert_lim_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TMR_RUN && $past(st_q) == TMR_RUN) |-> $stable(lim_q));
endmodule

// File: rtl/startup_delay_unit.sv
module startup_delay_unit
   import sdu_pkg::*;
#(
   parameter int unsigned CLK_PER_US = 100,
   parameter int unsigned TICKS_C0   = 50,
   parameter int unsigned TICKS_C1   = 500,
   parameter int unsigned TICKS_C2   = 1000,
   parameter int unsigned TICKS_CMAX = 2000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic        wr_ack,
   output logic        wr_nack,
   output logic [15:0] rd_data,
   input  logic        err_clr,
   output logic        err_summary,
   output logic        err_data,
   input  logic        start_req,
   output logic        ramp_go
);
   logic [CODE_W-1:0] code;
   logic              tick;

   sdu_cfg_reg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .err_clr    (err_clr),
      .wr_ack     (wr_ack),
      .wr_nack    (wr_nack),
      .err_summary(err_summary),
      .err_data   (err_data),
      .code       (code)
   );

   sdu_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   sdu_delay_timer #(
      .TICKS_C0  (TICKS_C0),
      .TICKS_C1  (TICKS_C1),
      .TICKS_C2  (TICKS_C2),
      .TICKS_CMAX(TICKS_CMAX)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start_req(start_req),
      .code     (code),
      .ramp_go  (ramp_go)
   );

   assign rd_data = {FIXED_BITS, code};

   assert_ack_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ack && wr_nack));
endmodule

// File: tb/sim_startup_delay_unit.sv
module sim_startup_delay_unit;
   localparam int P = 4;
   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, err_clr = 1'b0, start_req = 1'b0;
   logic [15:0] wr_data = '0;
   logic wr_ack, wr_nack, err_summary, err_data, ramp_go;
   logic [15:0] rd_data;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   startup_delay_unit #(.CLK_PER_US(P)) u0 (.*);

   // data[19:4], ack[3], expected code[2:0]
   localparam logic [19:0] WVEC [9] = '{
      {16'hF805, 1'b1, 3'd5}, {16'hF800, 1'b1, 3'd0}, {16'hF807, 1'b1, 3'd7},
      {16'h7807, 1'b0, 3'd7}, {16'hF808, 1'b0, 3'd7}, {16'hF803, 1'b1, 3'd3},
      {16'h0000, 1'b0, 3'd3}, {16'hFC02, 1'b0, 3'd3}, {16'hF802, 1'b1, 3'd2}};

   task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %0h exp %0h", rq, got, exp);
      end
   endtask

   task automatic chk_rng(input string rq, input int got, input int lo, input int hi);
      n_chk++;
      if (got < lo || got > hi) begin
         n_fail++;
         $display("FAIL %s got %0d exp %0d..%0d", rq, got, lo, hi);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // cycles from the start edge to the pulse, 0 if none within lim cycles
   task automatic run_delay(input int lim, output int d);
      @(negedge clk); start_req = 1'b1; d = 0;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (ramp_go) begin d = i; break; end
      end
   endtask

   task automatic delay_case(input string rq, input logic [2:0] c, input int t);
      int d;
      wr({13'h1F00, c});
      run_delay(t * P + 20, d);
      chk_rng(rq, d, (t - 1) * P, t * P + 3);
      @(negedge clk); chk({rq, " single pulse"}, ramp_go, 1'b0);
      start_req = 1'b0; @(negedge clk);
   endtask

   initial begin
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_data", rd_data, 16'hF800);
      chk("R1 flags", {err_summary, err_data, wr_ack, wr_nack, ramp_go}, 5'b0);

      for (int i = 0; i < 9; i++) begin
         @(negedge clk); wr_en = 1'b1; wr_data = WVEC[i][19:4];
         @(negedge clk); wr_en = 1'b0;
         if (WVEC[i][3]) chk("R2 ack", {wr_ack, wr_nack}, 2'b10);
         else            chk("R3 nack", {wr_ack, wr_nack}, 2'b01);
         chk(WVEC[i][3] ? "R2 readback" : "R3 unchanged", rd_data, {13'h1F00, WVEC[i][2:0]});
         if (i == 3) chk("R4 flags set", {err_summary, err_data}, 2'b11);
      end
      chk("R4 sticky after accepted write", {err_summary, err_data}, 2'b11);
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R4 cleared", {err_summary, err_data}, 2'b00);

      delay_case("R5 code0", 3'd0, 50);
      delay_case("R6 code1", 3'd1, 500);
      delay_case("R6 code2", 3'd2, 1000);
      for (int c = 3; c < 8; c++) delay_case("R7 code3-7", 3'(c), 2000);

      // R8: held start does not retrigger
      wr(16'hF800);
      run_delay(300, d);
      chk_rng("R8 first pulse", d, 49 * P, 50 * P + 3);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (ramp_go) begin chk("R8 no retrigger", 1'b1, 1'b0); break; end
      end
      chk("R8 held start idle", ramp_go, 1'b0);
      start_req = 1'b0; @(negedge clk);

      // R9: withdrawal aborts
      wr(16'hF802);
      @(negedge clk); start_req = 1'b1;
      repeat (100) @(negedge clk);
      start_req = 1'b0;
      d = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ramp_go) d = 1;
      end
      chk("R9 no pulse after abort", d, 0);

      // R10: mid-delay code change applies next time
      wr(16'hF801);
      @(negedge clk); start_req = 1'b1; d = 0;
      for (int i = 1; i <= 2400; i++) begin
         if (i == 50) begin wr_en = 1'b1; wr_data = 16'hF803; end
         if (i == 51) wr_en = 1'b0;
         @(negedge clk);
         if (ramp_go) begin d = i; break; end
      end
      chk_rng("R10 current delay kept", d, 499 * P, 500 * P + 3);
      start_req = 1'b0; @(negedge clk);
      run_delay(2000 * P + 20, d);
      chk_rng("R10 next start uses new code", d, 1999 * P, 2000 * P + 3);
      start_req = 1'b0; @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule